// File: doc/BRIEF.md
# Virtual Active-Priority Register Bank

This block keeps the active-priority state that a hypervisor saves and restores for a virtual interrupt interface. It holds four 64-bit registers. In each one the low 32 bits mark, one bit per level, which preemption levels have an interrupt in service. Bit 63 of register 0 can carry a flag for an active non-maskable interrupt. The block does no priority arithmetic. It stores the state and decides whether each system-register access is allowed.

Each request carries a read/write flag, a two-bit register index, the current privilege level (0 to 3), a three-bit nested-virtualization control word and one register-interface enable bit for each of levels 2 and 3. The request is settled in one of four ways:
- it reaches the register;
- it is redirected to a memory save area, and the block reports the address;
- it traps to a higher level with a syndrome class;
- it is flagged undefined.

The checks run in this order: register presence, then privilege level, then redirect or trap at level 1, then the interface-enable trap at levels 2 and 3. A parameter sets how many preemption bits are implemented (5, 6 or 7), and that number fixes which indices exist.

Top module: `vprio_apr_bank`

## Requirements
- R1: After reset every register reads as zero, and rsp_valid, mem_redirect, trap_req and undef are all low.
- R2: An index that is not implemented gives undef, whatever the level and control inputs are. Index 0 always exists. Index 1 needs PRE_BITS >= 6. Indices 2 and 3 need PRE_BITS >= 7.
- R3: A request from level 0 (cur_el = 0) on an implemented index gives undef.
- R4: At level 1, when nv_ctl[2] = 1 and nv_ctl[0] = 1, the response raises mem_redirect with mem_addr = 0x4A0 + 8 * index, and no register changes.
- R5: At level 1, when nv_ctl[0] = 1 and nv_ctl[2] = 0, the response is a trap with trap_el = 2 and trap_ec = 0x18. When nv_ctl[0] = 0, the response is undef.
- R6: At level 2 with sre_l2 = 0, or at level 3 with sre_l3 = 0, the response is a trap to that same level (trap_el = cur_el) with trap_ec = 0x18.
- R7: At level 2 with sre_l2 = 1, or at level 3 with sre_l3 = 1, a write stores the data in the register. A read returns the register value as it stood in the request cycle.
- R8: Bits 62 to 32 of every register always read as zero, and writes to them are ignored.
- R9: Bit 63 can be stored only in register 0, and only when NMI_EN = 1. In every other register it reads as zero.
- R10: A request that traps, is undefined or is redirected leaves every register unchanged.
- R11: Every request gets exactly one response, one cycle later, with at most one of mem_redirect, trap_req and undef high. Without a response all of these outputs, and rdata, mem_addr, trap_el and trap_ec, are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 2 | Register index |
| cur_el | input | 2 | Privilege level of the requester (0 to 3) |
| nv_ctl | input | 3 | Nested-virtualization control word; bit 2 and bit 0 are decoded |
| sre_l2 | input | 1 | Register interface enable for level 2 |
| sre_l3 | input | 1 | Register interface enable for level 3 |
| wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rdata | output | 64 | Read data (zero unless the response is a direct read) |
| mem_redirect | output | 1 | Access goes to the memory save area |
| mem_addr | output | 16 | Offset into the save area |
| trap_req | output | 1 | Access traps |
| trap_el | output | 2 | Level the trap is taken to |
| trap_ec | output | 6 | Syndrome class of the trap (0x18) |
| undef | output | 1 | Access is undefined |

## Verification
All results come out exactly one clock after the request is sampled: rsp_valid, the outcome flags, rdata, mem_addr and trap_el/trap_ec. A write to a register is visible to a read issued in the next request cycle.

The bench drives each request just after a falling edge. It reads the response one time unit after the following rising edge, which is the first point where that edge's registered results are stable. It then drops req_valid so that no second request is taken.

Idle cycles are checked at the same offset to confirm that every output has returned to zero.

// File: rtl/vprio_pkg.sv
package vprio_pkg;

  typedef enum logic [1:0] {
    OUT_REG   = 2'd0,
    OUT_MEM   = 2'd1,
    OUT_TRAP  = 2'd2,
    OUT_UNDEF = 2'd3
  } acc_out_e;

  typedef struct packed {
    acc_out_e   kind;
    logic [1:0] trap_el;
  } acc_dec_t;

  localparam logic [5:0] EC_SYSREG = 6'h18;

  // Register presence as a function of the implemented preemption bits.
  function automatic logic idx_present(input int unsigned pre_bits, input int unsigned idx);
    logic ok;
    if (idx == 0)      ok = 1'b1;
    else if (idx == 1) ok = (pre_bits >= 6);
    else               ok = (pre_bits >= 7);
    return ok;
  endfunction

  // Save-area offset for one register slot.
  function automatic logic [15:0] save_offset(input logic [15:0] base, input int unsigned idx);
    logic [15:0] off;
    off = base + 16'(idx * 8);
    return off;
  endfunction

endpackage

// File: rtl/vprio_access_dec.sv
module vprio_access_dec
  import vprio_pkg::*;
#(
  parameter int unsigned PRE_BITS = 6,
  parameter int unsigned IDX_W    = 2
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       el,
  input  logic [2:0]       nv,
  input  logic             sre_l2,
  input  logic             sre_l3,
  output acc_dec_t         dec,
  output logic             present
);

  always_comb begin
    present = idx_present(PRE_BITS, int'(idx));
  end

  always_comb begin
    dec.kind    = OUT_UNDEF;
    dec.trap_el = 2'd0;
    if (present) begin
      unique case (el)
        2'd0: dec.kind = OUT_UNDEF;
        2'd1: begin
          if (nv[2] && nv[0]) begin
            dec.kind = OUT_MEM;
          end else if (nv[0]) begin
            dec.kind    = OUT_TRAP;
            dec.trap_el = 2'd2;
          end else begin
            dec.kind = OUT_UNDEF;
          end
        end
        2'd2: begin
          if (!sre_l2) begin
            dec.kind    = OUT_TRAP;
            dec.trap_el = 2'd2;
          end else begin
            dec.kind = OUT_REG;
          end
        end
        default: begin
          if (!sre_l3) begin
            dec.kind    = OUT_TRAP;
            dec.trap_el = 2'd3;
          end else begin
            dec.kind = OUT_REG;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/vprio_apr_regs.sv
module vprio_apr_regs #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned PRIO_W   = 32,
  parameter bit          NMI_EN   = 1'b1,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned RSV_W   = DATA_W - PRIO_W - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] state_flat
);

  logic [DATA_W-1:0] view [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    logic [PRIO_W-1:0] prio_q;
    logic              nmi_bit;
    logic              sel;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prio_q <= '0;
      else if (sel) prio_q <= wr_data[PRIO_W-1:0];
    end

    if (g == 0 && NMI_EN) begin : g_nmi
      logic nmi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   nmi_q <= 1'b0;
        else if (sel) nmi_q <= wr_data[DATA_W-1];
      end
      assign nmi_bit = nmi_q;
    end else begin : g_no_nmi
      assign nmi_bit = 1'b0;
    end

    assign view[g] = {nmi_bit, {RSV_W{1'b0}}, prio_q};
    assign state_flat[g*DATA_W +: DATA_W] = view[g];
  end

  always_comb begin
    rd_data = view[rd_idx];
  end

endmodule

// File: rtl/vprio_apr_bank.sv
module vprio_apr_bank
  import vprio_pkg::*;
#(
  parameter int unsigned PRE_BITS  = 6,
  parameter bit          NMI_EN    = 1'b1,
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned PRIO_W    = 32,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] SAVE_BASE = 16'h04A0,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [1:0]        cur_el,
  input  logic [2:0]        nv_ctl,
  input  logic              sre_l2,
  input  logic              sre_l3,
  input  logic [DATA_W-1:0] wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_redirect,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              trap_req,
  output logic [1:0]        trap_el,
  output logic [5:0]        trap_ec,
  output logic              undef
);

  acc_dec_t                   dec;
  logic                       present;
  logic                       wr_en;
  logic                       rd_hit;
  logic [DATA_W-1:0]          rd_data;
  logic [NUM_REGS*DATA_W-1:0] state_flat;
  logic [ADDR_W-1:0]          addr_next;

  acc_out_e          kind_q;
  logic              vld_q;
  logic [1:0]        tel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rdata_q;

  vprio_access_dec #(
    .PRE_BITS(PRE_BITS),
    .IDX_W   (IDX_W)
  ) u_dec (
    .idx    (req_idx),
    .el     (cur_el),
    .nv     (nv_ctl),
    .sre_l2 (sre_l2),
    .sre_l3 (sre_l3),
    .dec    (dec),
    .present(present)
  );

  assign wr_en     = req_valid &&  req_write && (dec.kind == OUT_REG);
  assign rd_hit    = req_valid && !req_write && (dec.kind == OUT_REG);
  assign addr_next = ADDR_W'(save_offset(SAVE_BASE, int'(req_idx)));

  vprio_apr_regs #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .PRIO_W  (PRIO_W),
    .NMI_EN  (NMI_EN)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (req_idx),
    .wr_data   (wdata),
    .rd_idx    (req_idx),
    .rd_data   (rd_data),
    .state_flat(state_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      kind_q  <= OUT_REG;
      tel_q   <= 2'd0;
      addr_q  <= '0;
      rdata_q <= '0;
    end else begin
      vld_q   <= req_valid;
      kind_q  <= req_valid ? dec.kind : OUT_REG;
      tel_q   <= (req_valid && dec.kind == OUT_TRAP) ? dec.trap_el : 2'd0;
      addr_q  <= (req_valid && dec.kind == OUT_MEM) ? addr_next : '0;
      rdata_q <= rd_hit ? rd_data : '0;
    end
  end

  assign rsp_valid    = vld_q;
  assign rdata        = rdata_q;
  assign mem_redirect = vld_q && (kind_q == OUT_MEM);
  assign mem_addr     = addr_q;
  assign trap_req     = vld_q && (kind_q == OUT_TRAP);
  assign trap_el      = tel_q;
  assign trap_ec      = trap_req ? EC_SYSREG : 6'd0;
  assign undef        = vld_q && (kind_q == OUT_UNDEF);

endmodule

// File: rtl/vprio_apr_chk.sv
module vprio_apr_chk #(
  parameter int unsigned PRE_BITS = 6,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic [1:0]                 req_idx,
  input logic [1:0]                 cur_el,
  input logic [2:0]                 nv_ctl,
  input logic                       sre_l2,
  input logic                       sre_l3,
  input logic                       rsp_valid,
  input logic [DATA_W-1:0]          rdata,
  input logic                       mem_redirect,
  input logic [15:0]                mem_addr,
  input logic                       trap_req,
  input logic [1:0]                 trap_el,
  input logic                       undef,
  input logic [NUM_REGS*DATA_W-1:0] state_flat
);

  logic idx_ok;
  assign idx_ok = (req_idx == 2'd0) || (req_idx == 2'd1 && PRE_BITS >= 6) || (PRE_BITS >= 7);

  // R11
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R11
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !mem_redirect && !trap_req && !undef));

  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_redirect, trap_req, undef}));

  // R2
  absent_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !idx_ok) |=> undef);

  // R3
  lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cur_el == 2'd0) |=> undef);

  // R4
  save_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && idx_ok && cur_el == 2'd1 && nv_ctl[2] && nv_ctl[0])
      |=> (mem_redirect && mem_addr == 16'h04A0 + {11'd0, $past(req_idx), 3'd0}));

  // R6
  sre_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && idx_ok && ((cur_el == 2'd2 && !sre_l2) || (cur_el == 2'd3 && !sre_l3)))
      |=> (trap_req && trap_el == $past(cur_el)));

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[62:32] == 31'd0);

  // R10
  frozen_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_redirect || trap_req || undef) |-> $stable(state_flat));

endmodule

bind vprio_apr_bank vprio_apr_chk #(
  .PRE_BITS(PRE_BITS),
  .NUM_REGS(NUM_REGS),
  .DATA_W  (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_idx     (req_idx),
  .cur_el      (cur_el),
  .nv_ctl      (nv_ctl),
  .sre_l2      (sre_l2),
  .sre_l3      (sre_l3),
  .rsp_valid   (rsp_valid),
  .rdata       (rdata),
  .mem_redirect(mem_redirect),
  .mem_addr    (mem_addr),
  .trap_req    (trap_req),
  .trap_el     (trap_el),
  .undef       (undef),
  .state_flat  (state_flat)
);

// File: tb/test_vprio_apr_bank.sv
`timescale 1ns/1ps
module test_vprio_apr_bank;

  localparam int unsigned PRE = 6;
  localparam bit          NMI = 1'b1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_idx = '0, cur_el = '0;
  logic [2:0]  nv_ctl = '0;
  logic        sre_l2 = 1'b0, sre_l3 = 1'b0;
  logic [63:0] wdata = '0;
  logic        rsp_valid, mem_redirect, trap_req, undef;
  logic [63:0] rdata;
  logic [15:0] mem_addr;
  logic [1:0]  trap_el;
  logic [5:0]  trap_ec;

  int n_cmp = 0, n_bad = 0;
  logic [63:0] mdl [4];
  bit done = 1'b0;

  always #5 clk = ~clk;

  vprio_apr_bank #(.PRE_BITS(PRE), .NMI_EN(NMI)) i_vprio_apr_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_idx(req_idx), .cur_el(cur_el), .nv_ctl(nv_ctl), .sre_l2(sre_l2),
    .sre_l3(sre_l3), .wdata(wdata), .rsp_valid(rsp_valid), .rdata(rdata),
    .mem_redirect(mem_redirect), .mem_addr(mem_addr), .trap_req(trap_req),
    .trap_el(trap_el), .trap_ec(trap_ec), .undef(undef)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 reg, 1 save area, 2 trap, 3 undefined
  function automatic int outcome(input logic [1:0] i, input logic [1:0] el,
                                 input logic [2:0] nv, input logic s2, input logic s3);
    bit exists = (i == 0) || (i == 1 && PRE >= 6) || (PRE >= 7);
    if (!exists) return 3;
    if (el == 0) return 3;
    if (el == 2) return s2 ? 0 : 2;
    if (el == 3) return s3 ? 0 : 2;
    if (!nv[0]) return 3;
    return nv[2] ? 1 : 2;
  endfunction

  function automatic logic [63:0] keep_mask(input logic [1:0] i);
    logic [63:0] m = 64'h0000_0000_FFFF_FFFF;
    if (i == 0 && NMI) m[63] = 1'b1;
    return m;
  endfunction

  function automatic string tag_of(input int o, input logic [1:0] i, input logic [1:0] el);
    bit exists = (i == 0) || (i == 1 && PRE >= 6) || (PRE >= 7);
    if (!exists) return "R2";
    if (o == 3) return (el == 0) ? "R3" : "R5";
    if (o == 1) return "R4";
    if (o == 2) return (el == 1) ? "R5" : "R6";
    return "R7";
  endfunction

  task automatic xact(input bit w, input logic [1:0] i, input logic [1:0] el,
                      input logic [2:0] nv, input bit s2, input bit s3, input logic [63:0] d);
    int o;
    string t;
    logic [63:0] exp_rd;
    logic [15:0] exp_addr;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_idx = i; cur_el = el;
    nv_ctl = nv; sre_l2 = s2; sre_l3 = s3; wdata = d;
    o = outcome(i, el, nv, s2, s3);
    t = tag_of(o, i, el);
    exp_rd   = (o == 0 && !w) ? mdl[i] : 64'd0;
    exp_addr = (o == 1) ? 16'h04A0 + 16'(i) * 16'd8 : 16'd0;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    check({t, " R11 rsp_valid"}, 64'(rsp_valid), 64'd1);
    check({t, " outcome flags"}, 64'({mem_redirect, trap_req, undef}),
          64'({o == 1, o == 2, o == 3}));
    check({t, " rdata"}, rdata, exp_rd);
    check({t, " mem_addr"}, 64'(mem_addr), 64'(exp_addr));
    check({t, " trap_el/ec"}, 64'({trap_el, trap_ec}),
          (o == 2) ? 64'({el == 1 ? 2'd2 : el, 6'h18}) : 64'd0);
    if (o == 0 && w) mdl[i] = d & keep_mask(i);
  endtask

  task automatic idle_check();
    @(negedge clk);
    @(posedge clk);
    #1;
    check("R11 idle outputs", 64'({rsp_valid, mem_redirect, trap_req, undef, trap_ec}), 64'd0);
    check("R11 idle rdata", rdata, 64'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) mdl[k] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outputs", 64'({rsp_valid, mem_redirect, trap_req, undef}), 64'd0);
    rst_n = 1'b1;
    // R1: implemented registers read zero
    xact(1'b0, 2'd0, 2'd2, 3'd0, 1'b1, 1'b0, '0);
    xact(1'b0, 2'd1, 2'd3, 3'd0, 1'b0, 1'b1, '0);
    // R8/R9 mask behaviour
    xact(1'b1, 2'd0, 2'd3, 3'd0, 1'b0, 1'b1, '1);
    xact(1'b0, 2'd0, 2'd3, 3'd0, 1'b0, 1'b1, '0);
    check("R8 R9 reg0 image", mdl[0], 64'h8000_0000_FFFF_FFFF);
    xact(1'b1, 2'd1, 2'd2, 3'd0, 1'b1, 1'b0, '1);
    xact(1'b0, 2'd1, 2'd2, 3'd0, 1'b1, 1'b0, '0);
    // R2: absent indices, even with everything enabled
    xact(1'b1, 2'd2, 2'd3, 3'd5, 1'b1, 1'b1, '1);
    xact(1'b0, 2'd3, 2'd1, 3'd5, 1'b1, 1'b1, '0);
    // R3
    xact(1'b1, 2'd0, 2'd0, 3'd5, 1'b1, 1'b1, 64'h1234);
    // R4 redirect then read back unchanged (R10)
    xact(1'b1, 2'd1, 2'd1, 3'd7, 1'b0, 1'b0, 64'h0);
    xact(1'b0, 2'd1, 2'd2, 3'd0, 1'b1, 1'b0, '0);
    // R5 trap and undef at level 1
    xact(1'b1, 2'd0, 2'd1, 3'd1, 1'b1, 1'b1, 64'h0);
    xact(1'b1, 2'd0, 2'd1, 3'd4, 1'b1, 1'b1, 64'h0);
    // R6 traps, then R10 read back
    xact(1'b1, 2'd0, 2'd2, 3'd0, 1'b0, 1'b1, 64'h0);
    xact(1'b1, 2'd1, 2'd3, 3'd0, 1'b1, 1'b0, 64'h0);
    xact(1'b0, 2'd0, 2'd3, 3'd0, 1'b0, 1'b1, '0);
    // R11 idle
    idle_check();
    // R7 R10 random mix
    for (int n = 0; n < 600; n++) begin
      logic [1:0] el = 2'($urandom_range(3, 0));
      logic [2:0] nv = 3'($urandom);
      logic [63:0] d = {$urandom, $urandom};
      bit s2 = ($urandom_range(3, 0) != 0);
      bit s3 = ($urandom_range(3, 0) != 0);
      xact(1'($urandom), 2'($urandom), el, nv, s2, s3, d);
      if ((n % 50) == 0) idle_check();
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule